// File: doc/BRIEF.md
# Flash Mode-Transition Unlock Sequencer

This block sits in front of the mode logic of an on-chip flash controller. It watches register writes from the bus and decides when the flash array moves between normal reading and program/erase operation. Three registers are visible at the write port. The entry register arms program/erase operation. The key register opens an unlock window. The mode-control register carries the actual transition steps.

A mode-control value takes effect only after four writes in a fixed order. Software first writes the key, then the value, then its bitwise inverse, then the value again. An accepted value must also be the next step of the transition chain for the current state and operating speed. Some steps start a settling interval, whose length in cycles comes from the two wait inputs. The block raises busy for that interval. The reported mode flips only when the last interval of a chain has run out.

Any write that breaks the unlock order, any value that is out of the chain, and any attempt to enter program/erase at low speed is refused. Each of these cases raises a sticky error flag and leaves the mode-control value unchanged.

Top module: `flash_mode_seq`

## Requirements
- R1: After reset the mode output shows read (0), the mode-control value is 08h, and busy, the error flag and the entry enable are all 0.
- R2: A write to the entry register (select 0) whose upper byte is AAh copies data bit 0 into the entry enable, so AA01h arms it and AA00h clears it. Any entry write whose upper byte is not AAh clears the enable.
- R3: A mode-control value V is taken only on this write order: A5h to the key register (select 1), then V, ~V and V to the mode-control register (select 2). Only the low byte matters for these writes. Writes on select 3 are ignored and do not disturb the order.
- R4: Each of the following breaks the sequence, sets the error flag and keeps the old mode-control value: a key value other than A5h, a key write while an unlock is in progress, a mode-control write with no key, a wrong inverse, a wrong repeat, an entry write in mid-sequence, and a key or mode-control write while busy.
- R5: From read mode with the entry enable set, the accepted chain is 12h, then 92h then 82h at high speed (speed 00), or D2h then C2h at middle speed (speed 01). The chain then waits and the mode becomes program/erase (1).
- R6: From program/erase mode the accepted chain is 92h, then 12h, then 08h, after which the mode returns to read.
- R7: An unlocked value that is not the expected next step, or 12h from read mode while the entry enable is clear, sets the error flag and is not applied.
- R8: While the speed input has bit 1 set (low speed), every step of the read-to-program/erase chain is refused with the error flag.
- R9: Applying 12h (entering) or 92h (leaving) holds busy high for exactly wait1 cycles. Applying the final step (82h/C2h or 08h) holds busy high for wait2 cycles. A count of zero gives no busy cycle, and all other steps give none.
- R10: The mode output changes on the same clock edge where busy falls after the final step's wait, or at the final step itself when wait2 is zero.
- R11: The error flag stays set until reset, even while later valid sequences are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | 1 | register write strobe, one write per cycle |
| wr_sel | input | 2 | register select: 0 entry, 1 key, 2 mode-control, 3 unused |
| wr_data | input | 16 | write data |
| spd_mode | input | 2 | operating speed: 00 high, 01 middle, 1x low |
| wait1_cyc | input | 16 | length of the first settling wait in cycles |
| wait2_cyc | input | 16 | length of the second settling wait in cycles |
| mode_pe | output | 1 | 1 in program/erase mode, 0 in read mode |
| busy | output | 1 | settling wait in progress |
| seq_err | output | 1 | sticky sequence/refusal error |
| mctl_val | output | 8 | currently applied mode-control value |
| entry_en | output | 1 | program/erase entry enable |

## Verification
The assertions check several properties on every cycle. The error flag never drops once set. Every rise of the flag traces back to a break or a refusal. The mode-control value holds after any break or refusal. The timer counts down by one with no reload while busy. The unlock state only advances in order. The mode moves only when busy is low, and it lands on the matching final chain value. Only the bench scenarios show the full transition chains under both speeds. The same holds for the exact busy length for random wait counts, the refusal at low speed, and the many ways of breaking the unlock order, because each of these depends on a whole series of writes.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_KEY   = 2'd1,
    SEL_MCTL  = 2'd2,
    SEL_NONE  = 2'd3
  } fmt_sel_e;

  typedef enum logic [1:0] {
    U_IDLE,
    U_KEY,
    U_V1,
    U_NV
  } fmt_ulk_e;

  typedef enum logic [2:0] {
    C_RD,
    C_UP1,
    C_UP2,
    C_PE,
    C_DN1,
    C_DN2
  } fmt_chain_e;

  typedef enum logic [1:0] {
    W_NONE,
    W_ONE,
    W_TWO
  } fmt_wait_e;

  localparam logic [7:0] UNLOCK_KEY = 8'hA5;
  localparam logic [7:0] ENTRY_TAG  = 8'hAA;
  localparam logic [7:0] MCTL_RST   = 8'h08;

  // expected next mode-control value for a chain position and speed
  function automatic logic [7:0] fmt_expect(fmt_chain_e st, logic mid);
    case (st)
      C_RD:    fmt_expect = 8'h12;
      C_UP1:   fmt_expect = mid ? 8'hD2 : 8'h92;
      C_UP2:   fmt_expect = mid ? 8'hC2 : 8'h82;
      C_PE:    fmt_expect = 8'h92;
      C_DN1:   fmt_expect = 8'h12;
      C_DN2:   fmt_expect = 8'h08;
      default: fmt_expect = 8'h00;
    endcase
  endfunction

  function automatic fmt_wait_e fmt_wait_of(fmt_chain_e st);
    case (st)
      C_RD, C_PE:   fmt_wait_of = W_ONE;
      C_UP2, C_DN2: fmt_wait_of = W_TWO;
      default:      fmt_wait_of = W_NONE;
    endcase
  endfunction

  function automatic fmt_chain_e fmt_next(fmt_chain_e st);
    case (st)
      C_RD:    fmt_next = C_UP1;
      C_UP1:   fmt_next = C_UP2;
      C_UP2:   fmt_next = C_PE;
      C_PE:    fmt_next = C_DN1;
      C_DN1:   fmt_next = C_DN2;
      default: fmt_next = C_RD;
    endcase
  endfunction

  function automatic logic fmt_is_up(fmt_chain_e st);
    fmt_is_up = (st == C_RD) || (st == C_UP1) || (st == C_UP2);
  endfunction

  function automatic logic fmt_is_final(fmt_chain_e st);
    fmt_is_final = (st == C_UP2) || (st == C_DN2);
  endfunction

  function automatic logic fmt_is_low(logic [1:0] spd);
    fmt_is_low = spd[1];
  endfunction

endpackage

// File: rtl/fmt_unlock.sv
module fmt_unlock
  import fmt_pkg::*;
#(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [VW-1:0] wr_byte,
  input  logic          hold,
  output logic          acc,
  output logic [VW-1:0] acc_val,
  output logic          brk
);

  fmt_ulk_e      st_q, st_d;
  logic [VW-1:0] v_q, v_d;

  always_comb begin
    st_d = st_q;
    v_d  = v_q;
    acc  = 1'b0;
    brk  = 1'b0;
    if (wr_en) begin
      case (fmt_sel_e'(wr_sel))
        SEL_KEY: begin
          if (hold || st_q != U_IDLE || wr_byte != UNLOCK_KEY[VW-1:0]) begin
            brk  = 1'b1;
            st_d = U_IDLE;
          end else begin
            st_d = U_KEY;
          end
        end
        SEL_MCTL: begin
          if (hold) begin
            brk  = 1'b1;
            st_d = U_IDLE;
          end else begin
            case (st_q)
              U_KEY: begin
                v_d  = wr_byte;
                st_d = U_V1;
              end
              U_V1: begin
                if (wr_byte == ~v_q) st_d = U_NV;
                else begin
                  brk  = 1'b1;
                  st_d = U_IDLE;
                end
              end
              U_NV: begin
                st_d = U_IDLE;
                if (wr_byte == v_q) acc = 1'b1;
                else brk = 1'b1;
              end
              default: begin
                brk  = 1'b1;
                st_d = U_IDLE;
              end
            endcase
          end
        end
        SEL_ENTRY: begin
          if (st_q != U_IDLE) begin
            brk  = 1'b1;
            st_d = U_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign acc_val = v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= U_IDLE;
      v_q  <= '0;
    end else begin
      st_q <= st_d;
      v_q  <= v_d;
    end
  end

  p_brk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> st_q == U_IDLE);
  p_acc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> st_q == U_IDLE);
  p_nv_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == U_NV) |-> ($past(st_q) == U_V1 || $past(st_q) == U_NV));
  p_v1_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == U_V1) |-> ($past(st_q) == U_KEY || $past(st_q) == U_V1));

endmodule

// File: rtl/fmt_wait_tmr.sv
module fmt_wait_tmr #(
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_n,
  output logic              busy,
  output logic              done
);

  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_n;
    else if (cnt_q != '0)  cnt_q <= cnt_q - ONE;
  end

  assign busy = (cnt_q != '0);
  // the coming edge ends the wait
  assign done = (cnt_q == ONE) && !load;

  p_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_n != '0) |=> busy);
  p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> cnt_q == $past(cnt_q) - ONE);
  p_no_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);

endmodule

// File: rtl/fmt_trans.sv
module fmt_trans
  import fmt_pkg::*;
#(
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [7:0]        acc_val,
  input  logic [1:0]        spd,
  input  logic              entry_en,
  input  logic [WAIT_W-1:0] wait1,
  input  logic [WAIT_W-1:0] wait2,
  input  logic              tmr_busy,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic [WAIT_W-1:0] tmr_n,
  output logic              rej,
  output logic [7:0]        mctl_q,
  output logic              mode_q
);

  fmt_chain_e chain_q;
  logic       pend_q, tgt_q;
  logic [7:0] exp_val;
  logic       low_blk, en_blk, apply, fin, fin_tgt;
  fmt_wait_e  wk;

  always_comb begin
    exp_val  = fmt_expect(chain_q, spd[0]);
    low_blk  = fmt_is_up(chain_q) && fmt_is_low(spd);
    en_blk   = (chain_q == C_RD) && !entry_en;
    apply    = acc && (acc_val == exp_val) && !low_blk && !en_blk;
    rej      = acc && !apply;
    wk       = fmt_wait_of(chain_q);
    tmr_load = apply && (wk != W_NONE);
    tmr_n    = (wk == W_ONE) ? wait1 : wait2;
    fin      = fmt_is_final(chain_q);
    fin_tgt  = (chain_q == C_UP2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= C_RD;
      mctl_q  <= MCTL_RST;
      mode_q  <= 1'b0;
      pend_q  <= 1'b0;
      tgt_q   <= 1'b0;
    end else begin
      if (apply) begin
        mctl_q  <= acc_val;
        chain_q <= fmt_next(chain_q);
        if (fin) begin
          if (tmr_n == '0) mode_q <= fin_tgt;
          else begin
            pend_q <= 1'b1;
            tgt_q  <= fin_tgt;
          end
        end
      end else if (tmr_done && pend_q) begin
        mode_q <= tgt_q;
        pend_q <= 1'b0;
      end
    end
  end

  p_rise_val_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> (mctl_q == 8'h82 || mctl_q == 8'hC2));
  p_fall_val_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q) |-> mctl_q == 8'h08);
  p_rej_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> $stable(mctl_q));
  p_mode_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> !tmr_busy);

endmodule

// File: rtl/flash_mode_seq.sv
module flash_mode_seq
  import fmt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        spd_mode,
  input  logic [WAIT_W-1:0] wait1_cyc,
  input  logic [WAIT_W-1:0] wait2_cyc,
  output logic              mode_pe,
  output logic              busy,
  output logic              seq_err,
  output logic [7:0]        mctl_val,
  output logic              entry_en
);

  localparam int TAG_LO = DATA_W - 8;

  logic              acc, brk, rej, tmr_load, tmr_done, tmr_busy;
  logic [7:0]        acc_val;
  logic [WAIT_W-1:0] tmr_n;
  logic              entry_q, err_q, entry_wr;

  assign entry_wr = wr_en && (fmt_sel_e'(wr_sel) == SEL_ENTRY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (entry_wr)
        entry_q <= (wr_data[DATA_W-1:TAG_LO] == ENTRY_TAG) && wr_data[0];
      if (brk || rej) err_q <= 1'b1;
    end
  end

  fmt_unlock #(.VW(8)) ulk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_byte (wr_data[7:0]),
    .hold    (tmr_busy),
    .acc     (acc),
    .acc_val (acc_val),
    .brk     (brk)
  );

  fmt_trans #(.WAIT_W(WAIT_W)) trn_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .acc_val  (acc_val),
    .spd      (spd_mode),
    .entry_en (entry_q),
    .wait1    (wait1_cyc),
    .wait2    (wait2_cyc),
    .tmr_busy (tmr_busy),
    .tmr_done (tmr_done),
    .tmr_load (tmr_load),
    .tmr_n    (tmr_n),
    .rej      (rej),
    .mctl_q   (mctl_val),
    .mode_q   (mode_pe)
  );

  fmt_wait_tmr #(.WAIT_W(WAIT_W)) tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .load_n (tmr_n),
    .busy   (tmr_busy),
    .done   (tmr_done)
  );

  assign busy     = tmr_busy;
  assign seq_err  = err_q;
  assign entry_en = entry_q;

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(brk || rej));
  p_brk_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> $stable(mctl_val));
  p_entry_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_wr && wr_data[DATA_W-1:TAG_LO] != ENTRY_TAG) |=> !entry_q);

endmodule

// File: tb/flash_mode_seq_tb_top.sv
`timescale 1ns/1ps
module flash_mode_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic [1:0]  spd_mode = 2'b00;
  logic [15:0] wait1_cyc = 16'd3;
  logic [15:0] wait2_cyc = 16'd4;
  logic        mode_pe, busy, seq_err, entry_en;
  logic [7:0]  mctl_val;

  int  total = 0;
  int  bad = 0;
  bit  m_exp = 1'b0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  flash_mode_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .spd_mode(spd_mode), .wait1_cyc(wait1_cyc), .wait2_cyc(wait2_cyc),
    .mode_pe(mode_pe), .busy(busy), .seq_err(seq_err), .mctl_val(mctl_val),
    .entry_en(entry_en)
  );

  function automatic logic [7:0] up_mid(input logic [1:0] s);
    return (s == 2'b01) ? 8'hD2 : 8'h92;
  endfunction
  function automatic logic [7:0] up_last(input logic [1:0] s);
    return (s == 2'b01) ? 8'hC2 : 8'h82;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_exp = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unl(input logic [7:0] v);
    wr(2'd1, 16'h00A5);
    wr(2'd2, {8'h00, v});
    wr(2'd2, {8'h00, ~v});
    wr(2'd2, {8'h00, v});
  endtask

  task automatic step(input logic [7:0] v, input int n, input bit fin, input bit tgt,
                      input string tag);
    bit old;
    old = m_exp;
    unl(v);
    check({tag, " R3 value"}, mctl_val, v);
    if (n > 0) begin
      check({tag, " R9 busy start"}, busy, 1);
      check({tag, " R10 mode held"}, mode_pe, old);
      if (n > 1) begin
        repeat (n - 1) @(negedge clk);
        check({tag, " R9 busy last"}, busy, 1);
        check({tag, " R10 mode held late"}, mode_pe, old);
      end
      @(negedge clk);
    end
    check({tag, " R9 busy end"}, busy, 0);
    if (fin) m_exp = tgt;
    check({tag, " R10 mode"}, mode_pe, m_exp);
  endtask

  task automatic go_up(input logic [1:0] s, input int w1, input int w2, input string tag);
    spd_mode = s; wait1_cyc = 16'(w1); wait2_cyc = 16'(w2);
    wr(2'd0, 16'hAA01);
    check({tag, " R2 entry armed"}, entry_en, 1);
    step(8'h12, w1, 0, 0, {tag, " R5 up1"});
    step(up_mid(s), 0, 0, 0, {tag, " R5 up2"});
    step(up_last(s), w2, 1, 1, {tag, " R5 up3"});
  endtask

  task automatic go_down(input int w1, input int w2, input string tag);
    wait1_cyc = 16'(w1); wait2_cyc = 16'(w2);
    step(8'h92, w1, 0, 0, {tag, " R6 dn1"});
    step(8'h12, 0, 0, 0, {tag, " R6 dn2"});
    step(8'h08, w2, 1, 0, {tag, " R6 dn3"});
    wr(2'd0, 16'hAA00);
    check({tag, " R2 entry cleared"}, entry_en, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R1 reset state
    check("R1 mode", mode_pe, 0);
    check("R1 mctl", mctl_val, 8'h08);
    check("R1 busy", busy, 0);
    check("R1 err", seq_err, 0);
    check("R1 entry", entry_en, 0);

    // R2 entry register
    wr(2'd0, 16'hAA01); check("R2 AA01", entry_en, 1);
    wr(2'd0, 16'h5501); check("R2 bad tag", entry_en, 0);
    wr(2'd0, 16'hAA01); wr(2'd0, 16'hAA00); check("R2 AA00", entry_en, 0);

    // directed chains, high and middle speed, zero and nonzero waits
    go_up(2'b00, 3, 5, "hi");
    go_down(2, 1, "hi");
    go_up(2'b01, 0, 0, "mid0");
    go_down(0, 4, "mid0");
    check("R4 no error after clean chains", seq_err, 0);

    // R3 select 3 write in mid-sequence is ignored
    wr(2'd0, 16'hAA01);
    wr(2'd1, 16'h00A5); wr(2'd2, 16'h0012); wr(2'd3, 16'h1234);
    wr(2'd2, 16'h00ED); wr(2'd2, 16'h0012);
    check("R3 sel3 ignored value", mctl_val, 8'h12);
    check("R3 sel3 no error", seq_err, 0);

    // R4 mode-control write with no key
    do_reset();
    wr(2'd2, 16'h0012);
    check("R4 no key err", seq_err, 1); check("R4 no key mctl", mctl_val, 8'h08);
    // R4 wrong key value
    do_reset();
    wr(2'd1, 16'h005A);
    check("R4 bad key err", seq_err, 1);
    // R4 wrong inverse
    do_reset(); wr(2'd0, 16'hAA01);
    wr(2'd1, 16'h00A5); wr(2'd2, 16'h0012); wr(2'd2, 16'h0012);
    check("R4 bad inverse err", seq_err, 1); check("R4 bad inverse mctl", mctl_val, 8'h08);
    // R4 wrong repeat
    do_reset(); wr(2'd0, 16'hAA01);
    wr(2'd1, 16'h00A5); wr(2'd2, 16'h0012); wr(2'd2, 16'h00ED); wr(2'd2, 16'h0013);
    check("R4 bad repeat err", seq_err, 1); check("R4 bad repeat mctl", mctl_val, 8'h08);
    // R4 entry write in mid-sequence
    do_reset(); wr(2'd0, 16'hAA01);
    wr(2'd1, 16'h00A5); wr(2'd2, 16'h0012); wr(2'd0, 16'hAA01);
    wr(2'd2, 16'h00ED); wr(2'd2, 16'h0012);
    check("R4 entry mid err", seq_err, 1); check("R4 entry mid mctl", mctl_val, 8'h08);
    // R4 second key during unlock
    do_reset(); wr(2'd0, 16'hAA01);
    wr(2'd1, 16'h00A5); wr(2'd1, 16'h00A5);
    check("R4 double key err", seq_err, 1);
    // R4 write while busy
    do_reset(); wait1_cyc = 16'd20; wr(2'd0, 16'hAA01);
    unl(8'h12);
    check("R4 busy set", busy, 1);
    wr(2'd1, 16'h00A5);
    check("R4 busy write err", seq_err, 1); check("R4 busy write mctl", mctl_val, 8'h12);
    repeat (25) @(negedge clk);

    // R7 out-of-chain value and 12h without entry
    do_reset(); wr(2'd0, 16'hAA01); unl(8'h92);
    check("R7 wrong step err", seq_err, 1); check("R7 wrong step mctl", mctl_val, 8'h08);
    do_reset(); unl(8'h12);
    check("R7 no entry err", seq_err, 1); check("R7 no entry mctl", mctl_val, 8'h08);

    // R8 low speed refusal
    do_reset(); spd_mode = 2'b10; wr(2'd0, 16'hAA01); unl(8'h12);
    check("R8 low err", seq_err, 1); check("R8 low mctl", mctl_val, 8'h08);
    check("R8 low mode", mode_pe, 0);

    // R11 error stays across valid work
    go_up(2'b00, 2, 2, "sticky");
    check("R11 err kept", seq_err, 1);
    check("R11 mode reached", mode_pe, 1);

    // random rounds
    do_reset();
    for (int i = 0; i < 8; i++) begin
      logic [1:0] s;
      s = 2'($urandom % 2);
      go_up(s, int'($urandom % 13), int'($urandom % 13), "rnd");
      go_down(int'($urandom % 13), int'($urandom % 13), "rnd");
      check("rnd R4 clean", seq_err, 0);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule